// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block runs single read and write transfers on the external memory port of a 24-bit processor. An internal requester offers an address, a direction and write data. The controller drives active-low read and write strobes, a registered address and outgoing write data. It also drives an output enable for the 24-bit bidirectional data bus and an enable for the strobe drivers. When the transfer ends, it returns a one-cycle done pulse with the captured read data.

Every transfer lasts at least as many wait states as a programmed count sets. An external transfer-acknowledge input, which is active low, can hold a transfer open for any number of further cycles. That input is honoured only when the programmed count is one or more. A mode input decides whether the acknowledge is used as it arrives or is first passed through a two-flop synchronizer.

The pads themselves sit outside this block: the output enables gate the pad drivers. Arbitration is also outside the block, and it reports through the bus-ownership input.

Top module: `ext_bus_waitctl`

## Requirements
- R1: While reset is held (rst_n low), strobe_oe and bus_doe are 0, req_done is 0, and rd_n and wr_n are 1.
- R2: While bus_owner is 0, strobe_oe and bus_doe are 0 and a pending request does not start a transfer. No strobe and no req_done follow once ownership returns with the request withdrawn.
- R3: With N programmed wait states and the acknowledge held asserted, a read holds rd_n low for exactly N+1 cycles. wr_n stays 1 and bus_addr equals the request address throughout.
- R4: A write holds wr_n low for N+1 cycles under the same conditions. bus_doe is 1 and bus_dout equals the write data in every cycle wr_n is low. bus_doe is never 1 while rd_n is 0.
- R5: In synchronous mode (ack_async=0) with N≥1, the acknowledge may first be seen low in strobe cycle A, counting from 0. The strobe then stays low for max(N, A)+1 cycles.
- R6: With N=0, the strobe is low for exactly one cycle whatever the acknowledge does.
- R7: In synchronous mode the strobe length depends on the acknowledge rather than the programmed count alone when A>N. With ack_async=1 and N≥1, the acknowledge passes through two flops and the strobe stays low for max(N, A+2)+1 cycles.
- R8: req_done is 1 for exactly one cycle, in the cycle after the last strobe cycle. rd_data then holds the value bus_din had in the last strobe cycle of the read. rd_data keeps that value while no further read completes.
- R9: While no transfer is in progress, toggling xfer_ack_n produces no strobe and no req_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Transfer request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | 24 | Write data |
| wait_cfg | input | WAIT_W | Minimum wait-state count |
| ack_async | input | 1 | 1 = synchronize the acknowledge through two flops |
| bus_owner | input | 1 | This side owns the external bus |
| xfer_ack_n | input | 1 | Active-low transfer acknowledge |
| bus_din | input | 24 | Data bus input from the pads |
| bus_addr | output | ADDR_W | Registered transfer address |
| bus_dout | output | 24 | Data bus value to drive |
| bus_doe | output | 1 | Data bus output enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| strobe_oe | output | 1 | Strobe driver enable (0 = high impedance) |
| req_done | output | 1 | One-cycle completion pulse |
| rd_data | output | 24 | Captured read data |

## Verification
A state machine stuck in or out of its access state shows at once as a strobe held low or never asserted, and the strobe-length count exposes it on the first transfer. A wait counter that stops one step short or runs one step long gives a strobe-cycle count off by one against max(N, A)+1. This appears within a single transfer in each timing mode. A synchronizer stage too many or too few shifts the asynchronous length by a cycle. A wrong capture edge returns the bus value of a neighbouring strobe cycle, because the bench changes bus_din in every cycle.

// File: rtl/ebw_pkg.sv
package ebw_pkg;
  localparam int DATA_W = 24;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_FINISH = 2'd2
  } ebw_state_e;
endpackage

// File: rtl/ebw_ack_sync.sv
module ebw_ack_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_n_raw,
  input  logic async_mode,
  output logic ack_seen
);
  logic stage1_n, stage2_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_n <= 1'b1;
      stage2_n <= 1'b1;
    end else begin
      stage1_n <= ack_n_raw;
      stage2_n <= stage1_n;
    end
  end

  assign ack_seen = async_mode ? ~stage2_n : ~ack_n_raw;
endmodule

// File: rtl/ebw_wait_cnt.sv
module ebw_wait_cnt #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              run,
  input  logic [WAIT_W-1:0] limit,
  output logic              reached
);
  logic [WAIT_W-1:0] count;

  assign reached = (count == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              count <= '0;
    else if (start)          count <= '0;
    else if (run && !reached) count <= count + 1'b1;
  end
endmodule

// File: rtl/ext_bus_waitctl.sv
module ext_bus_waitctl
  import ebw_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [WAIT_W-1:0] wait_cfg,
  input  logic              ack_async,
  input  logic              bus_owner,
  input  logic              xfer_ack_n,
  input  logic [DATA_W-1:0] bus_din,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_doe,
  output logic              rd_n,
  output logic              wr_n,
  output logic              strobe_oe,
  output logic              req_done,
  output logic [DATA_W-1:0] rd_data
);
  function automatic logic may_finish(input logic reached, input logic zero_lat,
                                      input logic ack_ok);
    return reached && (zero_lat || ack_ok);
  endfunction

  ebw_state_e        state, state_nx;
  logic              wr_q;
  logic [WAIT_W-1:0] lat_q;
  logic [DATA_W-1:0] wdata_q;
  logic [ADDR_W-1:0] addr_q;

  // named internal events, used by the bound checker
  logic in_access, lat_zero, accept, access_exit, ack_seen, ack_ok, min_reached;

  assign in_access   = (state == ST_ACCESS);
  assign lat_zero    = (lat_q == '0);
  assign accept      = (state == ST_IDLE) && req_valid && bus_owner;
  assign ack_ok      = ack_seen && bus_owner && in_access;
  assign access_exit = in_access && may_finish(min_reached, lat_zero, ack_ok);

  ebw_ack_sync u_ack (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_n_raw (xfer_ack_n),
    .async_mode(ack_async),
    .ack_seen  (ack_seen)
  );

  ebw_wait_cnt #(.WAIT_W(WAIT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (accept),
    .run    (in_access),
    .limit  (lat_q),
    .reached(min_reached)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:   if (accept)      state_nx = ST_ACCESS;
      ST_ACCESS: if (access_exit) state_nx = ST_FINISH;
      ST_FINISH:                  state_nx = ST_IDLE;
      default:                    state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      wr_q    <= 1'b0;
      lat_q   <= '0;
      wdata_q <= '0;
      addr_q  <= '0;
      rd_data <= '0;
    end else begin
      state <= state_nx;
      if (accept) begin
        wr_q    <= req_write;
        lat_q   <= wait_cfg;
        wdata_q <= req_wdata;
        addr_q  <= req_addr;
      end
      if (access_exit && !wr_q) rd_data <= bus_din;
    end
  end

  assign rd_n      = !(in_access && !wr_q);
  assign wr_n      = !(in_access && wr_q);
  assign strobe_oe = bus_owner && rst_n;
  assign bus_doe   = in_access && wr_q && bus_owner && rst_n;
  assign bus_dout  = wdata_q;
  assign bus_addr  = addr_q;
  assign req_done  = (state == ST_FINISH);
endmodule

// File: rtl/ebw_checker.sv
module ebw_checker #(
  parameter int WAIT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_owner,
  input logic              in_access,
  input logic              lat_zero,
  input logic              access_exit,
  input logic [WAIT_W-1:0] lat_q,
  input logic              rd_n,
  input logic              wr_n,
  input logic              bus_doe,
  input logic              strobe_oe,
  input logic              req_done
);
  logic [15:0] strobe_cycles;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          strobe_cycles <= '0;
    else if (!in_access)                 strobe_cycles <= '0;
    else if (strobe_cycles != 16'hFFFF)  strobe_cycles <= strobe_cycles + 1'b1;
  end

  always_comb begin
    if (rst_n === 1'b0)
      p_reset_tristate_r1: assert (!strobe_oe && !bus_doe && !req_done);
  end

  p_no_owner_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_owner |-> (!strobe_oe && !bus_doe));

  p_min_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    access_exit |-> (strobe_cycles >= 16'(lat_q)));

  p_doe_vs_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_doe && !rd_n));

  p_zero_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_access && lat_zero) |-> access_exit);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_access |-> (rd_n && wr_n));
endmodule

bind ext_bus_waitctl ebw_checker #(.WAIT_W(WAIT_W)) u_ebw_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_owner  (bus_owner),
  .in_access  (in_access),
  .lat_zero   (lat_zero),
  .access_exit(access_exit),
  .lat_q      (lat_q),
  .rd_n       (rd_n),
  .wr_n       (wr_n),
  .bus_doe    (bus_doe),
  .strobe_oe  (strobe_oe),
  .req_done   (req_done)
);

// File: tb/tb_ext_bus_waitctl.sv
module tb_ext_bus_waitctl;
  localparam int AW = 18;
  localparam int WW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, ack_async = 0, bus_owner = 1, xfer_ack_n = 1;
  logic [AW-1:0] req_addr = '0;
  logic [23:0]   req_wdata = '0, bus_din = '0;
  logic [WW-1:0] wait_cfg = '0;
  logic [AW-1:0] bus_addr;
  logic [23:0]   bus_dout, rd_data;
  logic bus_doe, rd_n, wr_n, strobe_oe, req_done;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #2 clk = ~clk;

  ext_bus_waitctl #(.ADDR_W(AW), .WAIT_W(WW)) dut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input int n, input int a, input bit asy);
    int seen_at;
    seen_at = asy ? a + 2 : a;
    if (n == 0) return 1;
    return ((n > seen_at) ? n : seen_at) + 1;
  endfunction

  // one transfer; ack first driven low in strobe cycle a
  task automatic xfer(input bit wr, input int n, input int a, input bit asy,
                      input string req);
    int idx;
    bit doe_ok, addr_ok, other_ok;
    logic [23:0] last_in, wd;
    logic [AW-1:0] ad;
    idx = 0; doe_ok = 1; addr_ok = 1; other_ok = 1;
    wd = 24'h5A0000 + 24'(n * 16 + a);
    ad = AW'(18'h2A000 + n * 4 + a);
    ack_async = asy; wait_cfg = WW'(n);
    req_write = wr; req_addr = ad; req_wdata = wd; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    while (((wr ? wr_n : rd_n) == 1'b0) && idx < 300) begin
      if (idx == a) xfer_ack_n = 0;
      bus_din = 24'hC00000 + 24'(idx);
      last_in = bus_din;
      if (bus_addr != ad) addr_ok = 0;
      if ((wr ? rd_n : wr_n) != 1'b1) other_ok = 0;
      if (wr && (!bus_doe || bus_dout != wd)) doe_ok = 0;
      if (!wr && bus_doe) doe_ok = 0;
      idx++;
      @(negedge clk);
    end
    chk(idx == exp_len(n, a, asy), req, idx, exp_len(n, a, asy));
    chk(addr_ok && other_ok, "R3 address held, other strobe idle", {addr_ok, other_ok}, 2'b11);
    chk(doe_ok, "R4 data enable and write data", doe_ok, 1);
    bus_din = 24'h0F0F0F;
    chk(req_done == 1'b1, "R8 done after last strobe", req_done, 1);
    if (!wr) chk(rd_data == last_in, "R8 read capture", rd_data, last_in);
    xfer_ack_n = 1;
    @(negedge clk);
    chk(req_done == 1'b0, "R8 done one cycle", req_done, 0);
    if (!wr) chk(rd_data == last_in, "R8 read data held", rd_data, last_in);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    chk(!strobe_oe && !bus_doe && !req_done && rd_n && wr_n, "R1 reset state",
        {strobe_oe, bus_doe, req_done, rd_n, wr_n}, 5'b00011);
  endtask

  task automatic t_not_owner();
    bit ok;
    ok = 1;
    bus_owner = 0; req_valid = 1; req_write = 1;
    repeat (6) begin
      @(negedge clk);
      xfer_ack_n = ~xfer_ack_n;
      if (strobe_oe || bus_doe || req_done) ok = 0;
    end
    chk(ok, "R2 no drive without ownership", ok, 1);
    req_valid = 0; xfer_ack_n = 1;
    @(negedge clk);
    bus_owner = 1;
    repeat (3) begin
      @(negedge clk);
      if (!rd_n || !wr_n || req_done || !strobe_oe) ok = 0;
    end
    chk(ok, "R2 request dropped, drivers back", ok, 1);
  endtask

  task automatic t_idle_ack();
    bit ok;
    ok = 1;
    repeat (8) begin
      @(negedge clk);
      xfer_ack_n = ~xfer_ack_n;
      if (!rd_n || !wr_n || req_done) ok = 0;
    end
    xfer_ack_n = 1;
    repeat (3) @(negedge clk);
    chk(ok, "R9 idle acknowledge ignored", ok, 1);
  endtask

  initial begin
    t_reset();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    xfer(0, 2, 0, 0, "R3 read length");
    xfer(1, 3, 0, 0, "R4 write length");
    xfer(0, 2, 5, 0, "R5 ack stretches read");
    xfer(1, 4, 1, 0, "R5 programmed count dominates");
    xfer(0, 0, 9, 0, "R6 zero wait ignores ack");
    xfer(1, 0, 9, 1, "R6 zero wait async");
    xfer(0, 1, 0, 1, "R7 async sync delay");
    xfer(1, 3, 4, 1, "R7 async stretch");
    xfer(0, 15, 20, 0, "R5 maximum count stretched");
    t_idle_ack();
    t_not_owner();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule